// File: doc/BRIEF.md
# Memory-Card Host Interrupt Status and Mask Unit

This unit collects the event pulses produced by the command engine, the data engine and the card-detect logic of a memory-card host controller. It keeps them in a 32-bit sticky status word and combines them with a 32-bit disable mask into one level-sensitive interrupt line. Software acknowledges an event by writing a word to the status register: every position written as 0 is cleared and every position written as 1 keeps its value. This lets a handler clear exactly the events it served and leave any events that arrived later untouched.

Two live levels, card write-protect and command busy, are merged into the status word when it is read. They are never latched and never raise the interrupt. A second, 16-bit status and mask pair collects card-function interrupts. It drives its own interrupt line only while a transaction-enable register holds exactly 0x0001.

Registers are reached through a simple synchronous bus. It has a word address, a write enable and 32-bit write data, and it returns read data registered one cycle after the address is presented.

Top module: `sdhc_irq`

## Requirements
- R1: After reset the status word reads 0x00000000, the main mask reads 0x437B001D, the function mask reads 0x0000C001, the transaction-enable register reads 0, and both interrupt lines are low.
- R2: A one-cycle pulse on `evtIn[b]` sets status bit b, and the bit stays set until software clears it. Only the latched event positions can be set: 0, 2, 3, 4, 16, 17, 19, 20, 21, 22, 24, 25 and 30, which together form the valid set 0x437B001D.
- R3: A write to the status register at word address 0 clears every status bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When an event pulse and a clearing status write reach the same bit in the same cycle, the bit ends up set.
- R5: The main mask sits at word address 1, and a 1 in it disables that source. `irqOut` is high exactly when some status bit is set whose mask bit is 0.
- R6: Reading the status word returns `wrProtLvl` live in bit 7 and `cmdBusyLvl` live in bit 31. Neither level ever asserts `irqOut`.
- R7: Positions outside the valid set are not stored. They read as 0 in both the status and the mask registers, and pulses on them have no effect on `irqOut`.
- R8: The function status register sits at word address 2 and its mask at address 3. Only bits 0, 14 and 15 are valid, and bit 0 is the card interrupt. A pulse on `sdioEvtIn` latches into the function status, and writing 0 to a bit at address 2 clears it.
- R9: `sdioIrqOut` is high only when the transaction-enable register at address 4 holds exactly 0x0001 and an unmasked function status bit is set. Any other value, including 0x0000 and 0x0002, keeps the line low.
- R10: `busRdata` shows the register addressed in the previous cycle. Word addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Word address of the register |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| evtIn | input | 32 | Event pulses, one per status position |
| sdioEvtIn | input | 16 | Card-function event pulses |
| wrProtLvl | input | 1 | Live write-protect level |
| cmdBusyLvl | input | 1 | Live command-busy level |
| irqOut | output | 1 | Main interrupt request |
| sdioIrqOut | output | 1 | Card-function interrupt request |

## Verification
The hardest situation to reach is an event pulse that lands in the very cycle in which a status write clears the same bit. Reaching it takes the event input and the write strobe driven together, on the same falling edge. The bench lines both up in one task and then reads the status word back to confirm that the new event survived while every other bit was cleared. The function interrupt gate is also awkward to cover, because it depends on the exact value of the enable register. The bench therefore steps that register through 0, 2 and 1 while an unmasked function event stays pending.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FUNC_W = 16;

  // latched event positions
  localparam int unsigned BIT_RESP_END  = 0;
  localparam int unsigned BIT_DATA_END  = 2;
  localparam int unsigned BIT_CARD_OUT  = 3;
  localparam int unsigned BIT_CARD_IN   = 4;
  localparam int unsigned BIT_IDX_ERR   = 16;
  localparam int unsigned BIT_CRC_ERR   = 17;
  localparam int unsigned BIT_DATA_TO   = 19;
  localparam int unsigned BIT_RX_OVF    = 20;
  localparam int unsigned BIT_TX_UNF    = 21;
  localparam int unsigned BIT_CMD_TO    = 22;
  localparam int unsigned BIT_RX_READY  = 24;
  localparam int unsigned BIT_TX_REQ    = 25;
  localparam int unsigned BIT_BAD_ACC   = 30;
  // live level positions
  localparam int unsigned BIT_WR_PROT   = 7;
  localparam int unsigned BIT_CMD_BUSY  = 31;

  localparam logic [DATA_W-1:0] EVT_VALID =
      (32'd1 << BIT_RESP_END) | (32'd1 << BIT_DATA_END) | (32'd1 << BIT_CARD_OUT) |
      (32'd1 << BIT_CARD_IN)  | (32'd1 << BIT_IDX_ERR)  | (32'd1 << BIT_CRC_ERR)  |
      (32'd1 << BIT_DATA_TO)  | (32'd1 << BIT_RX_OVF)   | (32'd1 << BIT_TX_UNF)   |
      (32'd1 << BIT_CMD_TO)   | (32'd1 << BIT_RX_READY) | (32'd1 << BIT_TX_REQ)   |
      (32'd1 << BIT_BAD_ACC);

  localparam logic [FUNC_W-1:0] FUNC_VALID = 16'hC001;
  localparam logic [FUNC_W-1:0] FUNC_ENABLE_CODE = 16'h0001;

  // word addresses
  localparam int unsigned ADR_STAT      = 0;
  localparam int unsigned ADR_MASK      = 1;
  localparam int unsigned ADR_FUNC_STAT = 2;
  localparam int unsigned ADR_FUNC_MASK = 3;
  localparam int unsigned ADR_FUNC_EN   = 4;

  typedef enum logic [2:0] {
    SEL_STAT, SEL_MASK, SEL_FUNC_STAT, SEL_FUNC_MASK, SEL_FUNC_EN, SEL_NONE
  } readSel_e;

  typedef struct packed {
    logic     wrStat;
    logic     wrMask;
    logic     wrFuncStat;
    logic     wrFuncMask;
    logic     wrFuncEn;
    readSel_e readSel;
  } regStrobe_t;
endpackage

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
  import sdirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strb
);
  localparam int unsigned NUM_SEL = 5;

  logic [NUM_SEL-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_hit
      assign hit[i] = (busAddr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    strb.wrStat     = busWe && hit[ADR_STAT];
    strb.wrMask     = busWe && hit[ADR_MASK];
    strb.wrFuncStat = busWe && hit[ADR_FUNC_STAT];
    strb.wrFuncMask = busWe && hit[ADR_FUNC_MASK];
    strb.wrFuncEn   = busWe && hit[ADR_FUNC_EN];
    if (hit[ADR_STAT])           strb.readSel = SEL_STAT;
    else if (hit[ADR_MASK])      strb.readSel = SEL_MASK;
    else if (hit[ADR_FUNC_STAT]) strb.readSel = SEL_FUNC_STAT;
    else if (hit[ADR_FUNC_MASK]) strb.readSel = SEL_FUNC_MASK;
    else if (hit[ADR_FUNC_EN])   strb.readSel = SEL_FUNC_EN;
    else                         strb.readSel = SEL_NONE;
  end
endmodule

// File: rtl/sdirq_datapath.sv
module sdirq_datapath
  import sdirq_pkg::*;
#(
  parameter int unsigned       DW         = DATA_W,
  parameter int unsigned       FW         = FUNC_W,
  parameter logic [DW-1:0]     STAT_VALID = EVT_VALID,
  parameter logic [FW-1:0]     FVALID     = FUNC_VALID
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobe_t    strb,
  input  logic [DW-1:0] busWdata,
  input  logic [DW-1:0] evtIn,
  input  logic [FW-1:0] sdioEvtIn,
  input  logic          wrProtLvl,
  input  logic          cmdBusyLvl,
  output logic [DW-1:0] statQ,
  output logic [DW-1:0] maskQ,
  output logic [FW-1:0] funcStatQ,
  output logic [FW-1:0] funcMaskQ,
  output logic [FW-1:0] funcEnQ,
  output logic [DW-1:0] busRdata,
  output logic          irqOut,
  output logic          sdioIrqOut
);
  localparam int unsigned PAD_W = DW - FW;

  logic [DW-1:0] statNext;
  logic [FW-1:0] funcStatNext;
  logic [DW-1:0] levelWord;
  logic [DW-1:0] rdNext;

  // per-bit sticky update: an arriving event beats a clearing write
  generate
    for (genvar i = 0; i < DW; i++) begin : g_stat
      if (STAT_VALID[i]) begin : g_live
        assign statNext[i] = evtIn[i] |
                             (statQ[i] & ~(strb.wrStat & ~busWdata[i]));
      end else begin : g_dead
        assign statNext[i] = 1'b0;
      end
    end
    for (genvar j = 0; j < FW; j++) begin : g_func
      if (FVALID[j]) begin : g_live
        assign funcStatNext[j] = sdioEvtIn[j] |
                                 (funcStatQ[j] & ~(strb.wrFuncStat & ~busWdata[j]));
      end else begin : g_dead
        assign funcStatNext[j] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ     <= '0;
      maskQ     <= STAT_VALID;
      funcStatQ <= '0;
      funcMaskQ <= FVALID;
      funcEnQ   <= '0;
    end else begin
      statQ     <= statNext;
      funcStatQ <= funcStatNext;
      if (strb.wrMask)     maskQ     <= busWdata & STAT_VALID;
      if (strb.wrFuncMask) funcMaskQ <= busWdata[FW-1:0] & FVALID;
      if (strb.wrFuncEn)   funcEnQ   <= busWdata[FW-1:0];
    end
  end

  always_comb begin
    levelWord = '0;
    levelWord[BIT_WR_PROT]  = wrProtLvl;
    levelWord[BIT_CMD_BUSY] = cmdBusyLvl;
    unique case (strb.readSel)
      SEL_STAT:      rdNext = statQ | levelWord;
      SEL_MASK:      rdNext = maskQ;
      SEL_FUNC_STAT: rdNext = {{PAD_W{1'b0}}, funcStatQ};
      SEL_FUNC_MASK: rdNext = {{PAD_W{1'b0}}, funcMaskQ};
      SEL_FUNC_EN:   rdNext = {{PAD_W{1'b0}}, funcEnQ};
      default:       rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  assign irqOut     = |(statQ & STAT_VALID & ~maskQ);
  assign sdioIrqOut = (funcEnQ == FUNC_ENABLE_CODE) && |(funcStatQ & FVALID & ~funcMaskQ);
endmodule

// File: rtl/sdhc_irq.sv
module sdhc_irq
  import sdirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       evtIn,
  input  logic [15:0]       sdioEvtIn,
  input  logic              wrProtLvl,
  input  logic              cmdBusyLvl,
  output logic              irqOut,
  output logic              sdioIrqOut
);
  regStrobe_t  strb;
  logic [31:0] statQ;
  logic [31:0] maskQ;
  logic [15:0] funcStatQ;
  logic [15:0] funcMaskQ;
  logic [15:0] funcEnQ;

  sdirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  sdirq_datapath #(
    .DW         (DATA_W),
    .FW         (FUNC_W),
    .STAT_VALID (EVT_VALID),
    .FVALID     (FUNC_VALID)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .evtIn      (evtIn),
    .sdioEvtIn  (sdioEvtIn),
    .wrProtLvl  (wrProtLvl),
    .cmdBusyLvl (cmdBusyLvl),
    .statQ      (statQ),
    .maskQ      (maskQ),
    .funcStatQ  (funcStatQ),
    .funcMaskQ  (funcMaskQ),
    .funcEnQ    (funcEnQ),
    .busRdata   (busRdata),
    .irqOut     (irqOut),
    .sdioIrqOut (sdioIrqOut)
  );
endmodule

// File: rtl/sdhc_irq_chk.sv
module sdhc_irq_chk
  import sdirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       evtIn,
  input logic [31:0]       statQ,
  input logic [31:0]       maskQ,
  input logic [15:0]       funcEnQ,
  input logic              irqOut,
  input logic              sdioIrqOut
);
  logic statWr;
  assign statWr = busWe && (busAddr == ADDR_W'(ADR_STAT));

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((evtIn & EVT_VALID) != 0) |=> ((statQ & $past(evtIn & EVT_VALID)) == $past(evtIn & EVT_VALID))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statWr |=> ((statQ & ~$past(busWdata) & ~$past(evtIn)) == 0)); // R3

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!statWr && ((evtIn & EVT_VALID) == 0)) |=> $stable(statQ)); // R2

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == EVT_VALID) |-> !irqOut); // R5

  AST_FUNC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (funcEnQ != FUNC_ENABLE_CODE) |-> !sdioIrqOut); // R9
endmodule

bind sdhc_irq sdhc_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sdhc_irq.sv
module tb_sdhc_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] evtIn = '0;
  logic [15:0] sdioEvtIn = '0;
  logic        wrProtLvl = 1'b0;
  logic        cmdBusyLvl = 1'b0;
  logic        irqOut;
  logic        sdioIrqOut;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] VALID = 32'h437B001D;

  always #4 clk = ~clk;

  sdhc_irq dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn),
    .sdioEvtIn(sdioEvtIn), .wrProtLvl(wrProtLvl), .cmdBusyLvl(cmdBusyLvl),
    .irqOut(irqOut), .sdioIrqOut(sdioIrqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic pulse(input logic [31:0] e, input logic [15:0] f);
    @(negedge clk);
    evtIn = e; sdioEvtIn = f;
    @(negedge clk);
    evtIn = '0; sdioEvtIn = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 status", d, 32'h0);
    rd(3'd1, d); check("R1 mask", d, VALID);
    rd(3'd3, d); check("R1 func mask", d, 32'h0000C001);
    rd(3'd4, d); check("R1 func enable", d, 32'h0);
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    check("R1 func irq", {31'd0, sdioIrqOut}, 32'd0);
  endtask

  task automatic t_latch_mask();
    logic [31:0] d;
    pulse(32'h4, '0);
    rd(3'd0, d); check("R2 data end latched", d, 32'h4);
    check("R5 masked source quiet", {31'd0, irqOut}, 32'd0);
    wr(3'd1, VALID & ~32'h4);
    check("R5 unmasked source raises irq", {31'd0, irqOut}, 32'd1);
    rd(3'd0, d); check("R2 bit stays set", d, 32'h4);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(32'h0100_0001, '0);
    wr(3'd0, 32'hFFFF_FFFB);
    rd(3'd0, d); check("R3 selective clear", d, 32'h0100_0001);
    check("R5 irq off once unmasked bit cleared", {31'd0, irqOut}, 32'd0);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(32'h0000_0011, '0);
    @(negedge clk);
    busAddr = 3'd0; busWdata = 32'h0; busWe = 1'b1; evtIn = 32'h8;
    @(negedge clk);
    busWe = 1'b0; evtIn = '0;
    rd(3'd0, d); check("R4 event beats clear", d, 32'h8);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(3'd1, 32'h0);
    @(negedge clk);
    wrProtLvl = 1'b1; cmdBusyLvl = 1'b1;
    rd(3'd0, d); check("R6 live levels read", d, 32'h8000_0080);
    check("R6 levels no irq", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    wrProtLvl = 1'b0;
    rd(3'd0, d); check("R6 level follows input", d, 32'h8000_0000);
    cmdBusyLvl = 1'b0;
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    pulse(32'h0000_0122, '0);
    check("R7 invalid pulse no irq", {31'd0, irqOut}, 32'd0);
    rd(3'd0, d); check("R7 invalid not stored", d, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R7 mask only valid bits", d, VALID);
  endtask

  task automatic t_func();
    logic [31:0] d;
    pulse('0, 16'h0003);
    rd(3'd2, d); check("R8 func status latched", d, 32'h1);
    wr(3'd3, 32'h0000_C000);
    check("R9 enable 0 blocks", {31'd0, sdioIrqOut}, 32'd0);
    wr(3'd4, 32'h2);
    check("R9 enable 2 blocks", {31'd0, sdioIrqOut}, 32'd0);
    wr(3'd4, 32'h1);
    check("R9 enable 1 passes", {31'd0, sdioIrqOut}, 32'd1);
    wr(3'd4, 32'h0);
    check("R9 enable back to 0", {31'd0, sdioIrqOut}, 32'd0);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h0000_FFFE);
    rd(3'd2, d); check("R8 func clear by zero", d, 32'h0);
    check("R9 no pending no irq", {31'd0, sdioIrqOut}, 32'd0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R10 unused address reads zero", d, 32'h0);
    rd(3'd7, d); check("R10 top address reads zero", d, 32'h0);
    rd(3'd4, d); check("R10 enable readback", d, 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_latch_mask();
    t_clear();
    t_race();
    t_level();
    t_invalid();
    t_func();
    t_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule